// File: doc/BRIEF.md
# Random Bit Conditioner with Bias Alarm

This block cleans up the output of a set of already-sampled physical noise sources. On every cycle in which the sample strobe is high, it folds the whole group of source bits into one raw bit with an exclusive-OR tree. The raw bits are then taken two at a time, with no overlap between pairs. A pair of unequal bits yields one corrected output bit. A pair of equal bits yields nothing, so the rate of the output stream varies.

An on-line health monitor counts the ones among the corrected bits over fixed windows of 4096 bits. If a window ends with a count too far from one half, the monitor raises a sticky alarm. While the alarm is raised, no bit is delivered. A synchronous clear input drops the alarm. The consumer sees a valid strobe, a data bit and the alarm flag.

Top module: `trng_postproc`

## Requirements
- R1: The raw bit is the XOR of all NSRC source inputs, taken only in cycles where `sample_en` is high. Cycles with `sample_en` low leave the pair state unchanged.
- R2: Raw bits form consecutive non-overlapping pairs. A pair (first=0, second=1) produces corrected bit 1, and a pair (first=1, second=0) produces corrected bit 0. The bit appears on `out_bit`, with `out_valid` high for exactly one cycle, right after the clock edge that accepts the second sample.
- R3: A pair of equal raw bits, (0,0) or (1,1), produces no corrected bit, and `out_valid` stays low.
- R4: Every corrected bit is counted, whether or not it is delivered. At the edge that accepts the 4096th bit of a window, the alarm sets if the ones count of that window is below 1977 or above 2119. Counts of 1977 to 2119 inclusive pass. The window counters then restart from zero.
- R5: Once set, `alarm` stays high until a cycle with `alarm_clr` high. If a failing window closes in the same cycle as a clear, the alarm stays set.
- R6: While `alarm` is high, `out_valid` stays low. This includes the bit that closes the failing window.
- R7: Reset discards any half-collected pair, zeroes the window counters, and drives `out_valid` and `alarm` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | Accept one set of source bits this cycle |
| src_bits | input | NSRC | Sampled noise-source bits |
| alarm_clr | input | 1 | Synchronous clear of the bias alarm |
| out_valid | output | 1 | Corrected bit valid this cycle |
| out_bit | output | 1 | Corrected random bit |
| alarm | output | 1 | Sticky bias alarm |

## Verification
A corrected bit is due in the cycle right after the clock edge that accepts the second sample of its pair. The alarm rises on that same edge when the bit closes a failing window, and it falls on the edge that samples a clear.

The bench drives each stimulus just after a falling edge and lets one rising edge pass. It then advances its own reference state and compares all outputs at the next falling edge, so every result is read exactly one register stage after its cause. The directed windows place the ones count on both sides of each pass limit. One of them closes a failing window in the same cycle as a clear.

// File: rtl/trng_postproc.sv
module trng_postproc #(
  parameter int NSRC     = 8,
  parameter int WIN_LOG2 = 12,
  parameter int TOL      = 71
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_en,
  input  logic [NSRC-1:0] src_bits,
  input  logic            alarm_clr,
  output logic            out_valid,
  output logic            out_bit,
  output logic            alarm
);
  localparam int WIN  = 1 << WIN_LOG2;
  localparam int HALF = WIN / 2;
  localparam logic [WIN_LOG2:0] LO = (WIN_LOG2+1)'(HALF - TOL);
  localparam logic [WIN_LOG2:0] HI = (WIN_LOG2+1)'(HALF + TOL);

  logic                raw, emit, win_end, win_bad;
  logic                half_q, first_q, vld_q, bit_q;
  logic [WIN_LOG2-1:0] cnt_q;
  logic [WIN_LOG2:0]   ones_q, ones_tot;

  assign raw      = ^src_bits;
  assign emit     = sample_en & half_q & (first_q ^ raw);
  assign ones_tot = ones_q + {{WIN_LOG2{1'b0}}, raw};
  assign win_end  = emit & (&cnt_q);
  assign win_bad  = win_end & ((ones_tot < LO) | (ones_tot > HI));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_q  <= 1'b0;
      first_q <= 1'b0;
      vld_q   <= 1'b0;
      bit_q   <= 1'b0;
      cnt_q   <= '0;
      ones_q  <= '0;
      alarm   <= 1'b0;
    end else begin
      if (sample_en) begin
        half_q <= ~half_q;
        if (!half_q) first_q <= raw;
      end
      vld_q <= emit;
      if (emit) begin
        bit_q <= raw;
        if (win_end) begin
          cnt_q  <= '0;
          ones_q <= '0;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          ones_q <= ones_tot;
        end
      end
      if (win_bad)        alarm <= 1'b1;
      else if (alarm_clr) alarm <= 1'b0;
    end
  end

  assign out_valid = vld_q & ~alarm;
  assign out_bit   = bit_q;

  AST_VALID_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(sample_en) && $past(half_q)));                                    // R2
  AST_BIT_DIFFERS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bit != $past(first_q)));                                        // R2
  AST_EQUAL_PAIR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sample_en) && $past(half_q) && ($past(first_q) == $past(raw))) |-> !vld_q); // R3
  AST_ALARM_AT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(&cnt_q));                                                   // R4
  AST_WINDOW_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_end) |-> (cnt_q == '0 && ones_q == '0));                                 // R4
  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm);                                                  // R5
endmodule

// File: tb/test_trng_postproc.sv
module test_trng_postproc;
  localparam int K = 5;
  logic clk = 1'b0, rst_n = 1'b0, sample_en = 1'b0, alarm_clr = 1'b0;
  logic [K-1:0] src_bits = '0;
  logic out_valid, out_bit, alarm;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit m_half, m_first, m_vld, m_bit, m_alarm;
  int m_cnt, m_ones;

  always #2.5 clk = ~clk;

  trng_postproc #(.NSRC(K)) i_trng_postproc (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .src_bits(src_bits),
    .alarm_clr(alarm_clr), .out_valid(out_valid), .out_bit(out_bit), .alarm(alarm));

  function automatic logic [K-1:0] make_src(bit r);
    logic [K-1:0] v;
    v = K'($urandom);
    v[0] = v[0] ^ (^v) ^ r;
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    check(alarm === m_alarm, "R5", "alarm", alarm, m_alarm);
    check(out_valid === (m_vld & ~m_alarm), req, "out_valid", out_valid, m_vld & ~m_alarm);
    if (m_vld && !m_alarm) check(out_bit === m_bit, "R2", "out_bit", out_bit, m_bit);
  endtask

  task automatic step(bit en, bit r, bit clr, string req);
    bit emit, bad;
    sample_en = en; src_bits = make_src(r); alarm_clr = clr;
    @(posedge clk);
    emit = 0; bad = 0;
    if (en) begin
      if (!m_half) begin m_half = 1; m_first = r; end
      else begin m_half = 0; emit = (m_first != r); end
    end
    m_vld = emit;
    if (emit) begin
      m_bit = r; m_cnt++; m_ones += r;
      if (m_cnt == 4096) begin
        bad = (m_ones < 1977) || (m_ones > 2119);
        m_cnt = 0; m_ones = 0;
      end
    end
    if (bad) m_alarm = 1; else if (clr) m_alarm = 0;
    @(negedge clk);
    compare(req);
  endtask

  task automatic do_reset();
    rst_n = 0; sample_en = 0; alarm_clr = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    m_half = 0; m_vld = 0; m_alarm = 0; m_cnt = 0; m_ones = 0;
    check(out_valid === 1'b0, "R7", "out_valid in reset", out_valid, 0);
    check(alarm === 1'b0, "R7", "alarm in reset", alarm, 0);
    rst_n = 1;
  endtask

  task automatic emit_bit(bit b, bit clr);
    step(1, !b, 0, "R2");
    step(1, b, clr, "R6");
  endtask

  task automatic window(int n_ones, bit clr_last);
    for (int i = 0; i < 4096; i++) begin
      if ($urandom_range(0, 15) == 0) begin
        bit z = 1'($urandom);
        step(1, z, 0, "R3");
        step(1, z, 0, "R3");
      end
      emit_bit(i < n_ones, clr_last && i == 4095);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 190000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 190000);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    @(negedge clk);
    do_reset();
    // R1: random sampling with gaps and idle cycles
    for (int i = 0; i < 3000; i++)
      step($urandom_range(0, 9) < 7, 1'($urandom), $urandom_range(0, 63) == 0, "R1");
    // R1: idle cycles between halves are ignored
    step(1, 0, 0, "R1");
    for (int i = 0; i < 3; i++) step(0, 1, 0, "R1");
    step(1, 1, 0, "R1");
    check(out_valid === 1'b1 && out_bit === 1'b1, "R1", "gap pair (0,1)", out_bit, 1);
    // R3: equal pairs silent
    step(1, 1, 0, "R3"); step(1, 1, 0, "R3");
    check(out_valid === 1'b0, "R3", "pair (1,1)", out_valid, 0);
    step(1, 0, 0, "R3"); step(1, 0, 0, "R3");
    check(out_valid === 1'b0, "R3", "pair (0,0)", out_valid, 0);
    // R7: half pair discarded by reset
    step(1, 0, 0, "R7");
    do_reset();
    step(1, 1, 0, "R7");
    step(1, 0, 0, "R7");
    check(out_valid === 1'b1 && out_bit === 1'b0, "R7", "pair after reset", out_bit, 0);
    do_reset();
    // R4: window limits
    window(2048, 0);
    check(alarm === 1'b0, "R4", "balanced window", alarm, 0);
    window(2119, 0);
    check(alarm === 1'b0, "R4", "upper limit 2119", alarm, 0);
    window(2120, 1);
    check(alarm === 1'b1, "R4", "2120 ones with clear", alarm, 1);
    emit_bit(1, 0);
    check(out_valid === 1'b0, "R6", "suppressed while alarm", out_valid, 0);
    check(alarm === 1'b1, "R5", "alarm held", alarm, 1);
    step(0, 0, 1, "R5");
    check(alarm === 1'b0, "R5", "alarm cleared", alarm, 0);
    do_reset();
    window(1977, 0);
    check(alarm === 1'b0, "R4", "lower limit 1977", alarm, 0);
    window(1976, 0);
    check(alarm === 1'b1, "R4", "1976 ones", alarm, 1);
    step(0, 0, 1, "R5");
    check(alarm === 1'b0, "R5", "clear", alarm, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule